// File: doc/BRIEF.md
# Set/Clear Mask Interrupt Controller

This block collects 64 interrupt request lines and presents a single winner to the processor side. Each source carries a mask bit and a three-bit priority level. Software programs the level through a byte-wide control register per source. It enables or blocks one source by writing that source's number to one of two command bytes, so no read-modify-write of a bitmap is ever needed. Two reserved command values act on every source at once: one blocks all sources, the other enables all sources.

Every cycle a priority tree looks at the sources that are requesting, unmasked and programmed with a non-zero level. The highest level wins, and a tie goes to the lower source number. The winning level and source number leave the block through registers. The processor acknowledges with a one-cycle pulse. The block then returns the number it was offering and freezes its offer for that edge. Removing the request stays with the source.

A small state machine tracks the offer. Its states are NOREQ (nothing offered), OFFER (a source is offered) and HELD (the cycle after an acknowledge). Its transitions are: NOREQ→OFFER when a winner exists; OFFER→NOREQ when the winner disappears; any state→HELD on acknowledge; HELD→OFFER or HELD→NOREQ on the next cycle without acknowledge, depending on whether a winner exists. Every other case stays in the current state.

Top module: `smic_top`

## Requirements
- R1: After reset all 64 mask bits are 1 and all levels are 0. `irq_level` and `irq_src` read 0, `ack_vld` is 0, and no request reaches the outputs until a source is unmasked.
- R2: A write of value n (0..63) to address 64 (set-mask command) sets mask bit n only, which blocks source n.
- R3: A write of value n (0..63) to address 65 (clear-mask command) clears mask bit n only, which enables source n.
- R4: Writing 0xFF to address 64 sets all 64 mask bits.
- R5: Writing 0x40 to address 65 clears all 64 mask bits.
- R6: Values 64..254 written to address 64 and values 65..255 written to address 65 leave the mask unchanged. Writes to addresses 66..127 change nothing.
- R7: A write to address n (0..63) stores bits [2:0] of the data as the level of source n and ignores bits [7:3]. A source with level 0 never wins.
- R8: Among sources that are requesting, unmasked and at a non-zero level, the highest level wins and a tie goes to the lowest source number. `irq_level`/`irq_src` show the winner, or 0/0 when there is none.
- R9: A change on `irq_req` shows on the outputs after the next rising edge. A register write sampled at one edge shows after the following edge.
- R10: When `ack` is high at an edge, `irq_level` and `irq_src` keep their values at that edge. After that edge `ack_vld` is 1 and `ack_id` equals the `irq_src` that was being offered. `ack_vld` returns to 0 after the next edge without `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 64 | Request level from each source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write address: 0..63 level registers, 64 set-mask, 65 clear-mask |
| wr_data | input | 8 | Write data byte |
| ack | input | 1 | Processor acknowledge pulse |
| irq_level | output | 3 | Level of the offered source, 0 when none |
| irq_src | output | 6 | Number of the offered source |
| ack_vld | output | 1 | High for the cycle after an acknowledge (state HELD) |
| ack_id | output | 6 | Source number captured on acknowledge |

## Verification
The hardest situation to reach is an acknowledge that lands on the same edge as a change in the winner. At that edge the outputs must freeze even though the priority tree already points at a new source. The bench presents one source and then, on the same falling edge, raises `ack` and adds a higher-level request. It checks that the old number is held and returned, and that the new winner appears only one edge later. The ignored command values are also awkward, because they need a mask that is partly set. The bench leaves one source masked while it writes out-of-range values, so any stray set or clear would show as a change of winner.

// File: rtl/smic_pkg.sv
package smic_pkg;
    localparam int NSRC  = 64;
    localparam int LVLW  = 3;
    localparam int DW    = 8;
    localparam int ADDRW = 7;
    localparam int IDW   = $clog2(NSRC);

    localparam logic [ADDRW-1:0] SETM_ADDR = ADDRW'(NSRC);
    localparam logic [ADDRW-1:0] CLRM_ADDR = ADDRW'(NSRC + 1);
    localparam logic [DW-1:0]    SET_ALL   = '1;
    localparam logic [DW-1:0]    CLR_ALL   = DW'(NSRC);

    typedef enum logic [1:0] {
        ST_NOREQ = 2'd0,
        ST_OFFER = 2'd1,
        ST_HELD  = 2'd2
    } smic_state_e;
endpackage

// File: rtl/smic_mask_bank.sv
module smic_mask_bank
    import smic_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADDRW-1:0] wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [N-1:0]     mask
);
    localparam logic [DW-1:0] N_B = DW'(N);

    logic set_sel, clr_sel, in_range;
    logic [IDW-1:0] bit_idx;

    assign set_sel  = wr_en && (wr_addr == SETM_ADDR);
    assign clr_sel  = wr_en && (wr_addr == CLRM_ADDR);
    assign in_range = (wr_data < N_B);
    assign bit_idx  = wr_data[IDW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (set_sel) begin
            if (wr_data == SET_ALL)
                mask <= '1;
            else if (in_range)
                mask[bit_idx] <= 1'b1;
        end else if (clr_sel) begin
            if (wr_data == CLR_ALL)
                mask <= '0;
            else if (in_range)
                mask[bit_idx] <= 1'b0;
        end
    end

    AST_SET_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_sel && in_range) |=> mask[$past(bit_idx)]); // R2
    AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel && in_range) |=> !mask[$past(bit_idx)]); // R3
    AST_SET_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (set_sel && wr_data == SET_ALL) |=> (&mask)); // R4
    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel && wr_data == CLR_ALL) |=> (mask == '0)); // R5
    AST_SET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (set_sel && !in_range && wr_data != SET_ALL) |=> $stable(mask)); // R6
    AST_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel && !in_range && wr_data != CLR_ALL) |=> $stable(mask)); // R6
endmodule

// File: rtl/smic_level_bank.sv
module smic_level_bank
    import smic_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDRW-1:0]      wr_addr,
    input  logic [LVLW-1:0]       wr_lvl,
    output logic [N-1:0][LVLW-1:0] lvl
);
    localparam logic [ADDRW-1:0] N_A = ADDRW'(N);

    logic hit;
    assign hit = wr_en && (wr_addr < N_A);

    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl <= '0;
        else if (hit)
            lvl[wr_addr[IDW-1:0]] <= wr_lvl;
    end

    AST_LVL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (lvl[$past(wr_addr[IDW-1:0])] == $past(wr_lvl))); // R7
endmodule

// File: rtl/smic_prio_tree.sv
module smic_prio_tree
    import smic_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]           req,
    input  logic [N-1:0]           mask,
    input  logic [N-1:0][LVLW-1:0] lvl,
    output logic                   win_vld,
    output logic [LVLW-1:0]        win_lvl,
    output logic [IDW-1:0]         win_idx
);
    localparam int P = 1 << IDW;

    logic                nv [2*P];
    logic [LVLW-1:0]     nl [2*P];
    logic [IDW-1:0]      ni [2*P];

    assign nv[0] = 1'b0;
    assign nl[0] = '0;
    assign ni[0] = '0;

    for (genvar i = 0; i < P; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign nv[P+i] = req[i] && !mask[i] && (lvl[i] != '0);
            assign nl[P+i] = lvl[i];
        end else begin : g_pad
            assign nv[P+i] = 1'b0;
            assign nl[P+i] = '0;
        end
        assign ni[P+i] = IDW'(i);
    end

    for (genvar k = 1; k < P; k++) begin : g_node
        logic take_l;
        assign take_l = nv[2*k] && (!nv[2*k+1] || nl[2*k] >= nl[2*k+1]);
        assign nv[k]  = nv[2*k] || nv[2*k+1];
        assign nl[k]  = take_l ? nl[2*k] : nl[2*k+1];
        assign ni[k]  = take_l ? ni[2*k] : ni[2*k+1];
    end

    assign win_vld = nv[1];
    assign win_lvl = nl[1];
    assign win_idx = ni[1];
endmodule

// File: rtl/smic_top.sv
module smic_top
    import smic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  irq_req,
    input  logic             wr_en,
    input  logic [ADDRW-1:0] wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             ack,
    output logic [LVLW-1:0]  irq_level,
    output logic [IDW-1:0]   irq_src,
    output logic             ack_vld,
    output logic [IDW-1:0]   ack_id
);
    logic [NSRC-1:0]           mask;
    logic [NSRC-1:0][LVLW-1:0] lvl;
    logic                      win_vld;
    logic [LVLW-1:0]           win_lvl;
    logic [IDW-1:0]            win_idx;
    smic_state_e               state_q, state_d;

    smic_mask_bank #(.N(NSRC)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .mask(mask)
    );

    smic_level_bank #(.N(NSRC)) u_lvl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_lvl(wr_data[LVLW-1:0]), .lvl(lvl)
    );

    smic_prio_tree #(.N(NSRC)) u_tree (
        .req(irq_req), .mask(mask), .lvl(lvl),
        .win_vld(win_vld), .win_lvl(win_lvl), .win_idx(win_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NOREQ: if (ack) state_d = ST_HELD;
                      else if (win_vld) state_d = ST_OFFER;
            ST_OFFER: if (ack) state_d = ST_HELD;
                      else if (!win_vld) state_d = ST_NOREQ;
            ST_HELD:  if (ack) state_d = ST_HELD;
                      else if (win_vld) state_d = ST_OFFER;
                      else state_d = ST_NOREQ;
            default:  state_d = ST_NOREQ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NOREQ;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level <= '0;
            irq_src   <= '0;
            ack_id    <= '0;
        end else if (ack) begin
            ack_id    <= irq_src;
        end else begin
            irq_level <= win_vld ? win_lvl : '0;
            irq_src   <= win_vld ? win_idx : '0;
        end
    end

    assign ack_vld = (state_q == ST_HELD);

    AST_WIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> (irq_req[win_idx] && !mask[win_idx] &&
                     lvl[win_idx] == win_lvl && win_lvl != '0)); // R8
    AST_NOREQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NOREQ) |-> (irq_level == '0)); // R9
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ($stable(irq_level) && $stable(irq_src))); // R10
    AST_ACK_ID: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (ack_vld && ack_id == $past(irq_src))); // R10
endmodule

// File: tb/smic_top_tb.sv
`timescale 1ns/1ps
module smic_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_req = '0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ack = 1'b0;
    logic [2:0]  irq_level;
    logic [5:0]  irq_src;
    logic        ack_vld;
    logic [5:0]  ack_id;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    smic_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ack(ack),
        .irq_level(irq_level), .irq_src(irq_src),
        .ack_vld(ack_vld), .ack_id(ack_id)
    );

    // {request vector, expected level, expected source}; level of source i is i%8
    localparam logic [72:0] VEC [8] = '{
        {64'h0,                  3'd0, 6'd0},
        {64'h20,                 3'd5, 6'd5},
        {64'h2020,               3'd5, 6'd5},
        {64'h4000_0000_0000_0008, 3'd6, 6'd62},
        {64'h100,                3'd0, 6'd0},
        {64'h8000_0000_0000_8080, 3'd7, 6'd7},
        {64'h6,                  3'd2, 6'd2},
        {64'h8000_0000_0000_0001, 3'd7, 6'd63}
    };

    task automatic chk(input string tag, input logic [2:0] el, input logic [5:0] es);
        checks++;
        if (irq_level !== el || irq_src !== es) begin
            failures++;
            $display("FAIL %s: level/src=%0d/%0d expected %0d/%0d", tag, irq_level, irq_src, el, es);
        end
    endtask

    task automatic chk_ack(input string tag, input logic ev, input logic [5:0] eid);
        checks++;
        if (ack_vld !== ev || (ev && ack_id !== eid)) begin
            failures++;
            $display("FAIL %s: ack_vld/id=%0d/%0d expected %0d/%0d", tag, ack_vld, ack_id, ev, eid);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic req_set(input logic [63:0] r);
        irq_req = r;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: expired expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", 3'd0, 6'd0);
        chk_ack("R1 reset ack", 1'b0, 6'd0);

        for (int i = 0; i < 64; i++) wr(7'(i), 8'(i % 8));
        req_set('1);
        chk("R1 all masked after reset", 3'd0, 6'd0);

        wr(7'd65, 8'h40);                 // R5 unmask all
        for (int v = 0; v < 8; v++) begin
            req_set(VEC[v][72:9]);
            chk($sformatf("R8 vector %0d", v), VEC[v][8:6], VEC[v][5:0]);
        end

        req_set(64'h8080);
        chk("R8 tie low number", 3'd7, 6'd7);
        wr(7'd64, 8'd7);
        chk("R2 set mask 7", 3'd7, 6'd15);
        wr(7'd64, 8'd100);
        chk("R6 set value 100 ignored", 3'd7, 6'd15);
        wr(7'd65, 8'd200);
        chk("R6 clear value 200 ignored", 3'd7, 6'd15);
        wr(7'd65, 8'hFF);
        chk("R6 clear value 255 ignored", 3'd7, 6'd15);
        wr(7'd100, 8'd7);
        chk("R6 unmapped address ignored", 3'd7, 6'd15);
        wr(7'd65, 8'd7);
        chk("R3 clear mask 7", 3'd7, 6'd7);
        wr(7'd64, 8'hFF);
        chk("R4 set all", 3'd0, 6'd0);
        wr(7'd65, 8'h40);
        chk("R5 clear all", 3'd7, 6'd7);

        wr(7'd40, 8'hFA);
        req_set(64'h1 << 40);
        chk("R7 level low bits", 3'd2, 6'd40);
        wr(7'd40, 8'h08);
        chk("R7 level zero never wins", 3'd0, 6'd0);

        req_set(64'h0);
        irq_req = 64'h20;
        @(negedge clk);
        chk("R9 one edge latency", 3'd5, 6'd5);

        ack = 1'b1;
        irq_req = 64'h8000_0000_0000_0020;
        @(negedge clk);
        chk("R10 outputs held on ack", 3'd5, 6'd5);
        chk_ack("R10 ack returns id", 1'b1, 6'd5);
        ack = 1'b0;
        @(negedge clk);
        chk("R10 new winner after ack", 3'd7, 6'd63);
        chk_ack("R10 ack_vld drops", 1'b0, 6'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule